// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter that talks to a host over a synchronous serial link. The host lowers chip select and clocks a bit stream in on the data input. The block skips idle zeros and takes the first 1 as the start marker. It then captures a short channel-assignment word, which drives the analog multiplexer's mode and address outputs.

Once the word is in, the block runs a binary search. It presents a trial code to the internal DAC and reads a one-bit comparator verdict on each serial clock. Every verdict is placed on the serial data output on the next falling edge, most significant bit first, so the host reads the result while the conversion is still running. A busy flag spans the conversion. Chip select going high at any point returns the block to idle and puts the output into the high-impedance state. The DAC, the comparator and the track/hold are outside the block.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is high at a rising edge, `dout_oe` and `busy` are 0 from the following falling edge on, and the block is idle.
- R2: While hunting, `din` is sampled on rising edges and zeros are skipped. The first 1 sampled is the start bit. Until the conversion starts, `dout_oe` and `busy` stay 0.
- R3: The WORD_LEN = 2 + SEL_BITS bits after the start bit form the assignment word, MSB first. The first word bit appears on `mux_single` (1 = single-ended, 0 = differential). The remaining bits appear on `mux_addr`, first received bit as MSB. Both outputs are loaded on the rising edge that takes the last word bit.
- R4: On the falling edge after the last word bit is taken, `busy` and `dout_oe` go to 1 and `dout` drives a leading 0.
- R5: After the word is complete, `din` has no effect until `cs_n` has been high. No second conversion starts and the multiplexer outputs hold.
- R6: `dac_code` is 8'h80 right after the word. On each of the next 8 rising edges the trial bit under test is kept if `cmp_hi` is 1 and cleared if it is 0, and the next lower bit is set. The result is the binary value for which `cmp_hi` means input >= trial.
- R7: The verdict taken on each decision edge appears on `dout` at the following falling edge, MSB first.
- R8: `busy` falls at the falling edge after the eighth decision, the same edge on which `dout` shows the LSB. After that, `dac_code` holds the final result and `dout_oe` stays 1 while `cs_n` stays low.
- R9: Raising `cs_n` during a conversion aborts it (`busy` = 0, `dout_oe` = 0 at the next falling edge). The next conversion needs a new start bit.
- R10: A low `rst_n` at a rising edge (and at the falling edge for the output stage) clears all state to idle with `dac_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; control on rising, data out on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high aborts and idles |
| din | input | 1 | Serial data in (start bit and assignment word) |
| cmp_hi | input | 1 | Comparator verdict: 1 when input >= `dac_code` |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| busy | output | 1 | High while the conversion is running |
| mux_single | output | 1 | 1 = single-ended, 0 = differential |
| mux_addr | output | SEL_BITS+1 | Channel or pair/polarity address |
| dac_code | output | RES_BITS | Trial code for the DAC; final result after the conversion |

## Verification
Let E0 be the rising edge that takes the last word bit. Mux outputs and `dac_code` = 8'h80 are due at E0. `busy`, `dout_oe` and the leading zero are due half a clock later. Each verdict bit is due half a clock after its decision edge E1..E8, and `busy` falls half a clock after E8. The bench drives inputs one nanosecond after each falling edge and samples one nanosecond before the next rising edge. At that point every output set by either edge of the cycle has settled and no new input has been clocked in. The scoreboard monitor pops one expected serial bit at each such sample while `busy` is high, plus one on the sample where `busy` has just fallen. Abort cases check `busy` and `dout_oe` one falling edge after the rising edge that sees `cs_n` high.

// File: rtl/sar_seq_pkg.sv
// Package: shared types of the serial SAR sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_seq_pkg;

    // Front-end phases: looking for the start bit, reading the word, done.
    typedef enum logic [1:0] {
        FE_HUNT = 2'd0,
        FE_ADDR = 2'd1,
        FE_LOCK = 2'd2
    } fe_state_t;

endpackage

// File: rtl/sar_seq_frontend.sv
// Module: serial front end. Skips idle zeros on din and takes the first 1
// as start. It then shifts in the channel-assignment word, loads the
// multiplexer outputs and pulses conv_start in the cycle of the last word
// bit. After that it ignores din until chip select has been high.
// Assumes: din and cs_n are stable around rising clock edges.
module sar_seq_frontend
    import sar_seq_pkg::*;
#(
    parameter int SEL_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                din,
    output logic                conv_start,
    output logic                mux_single,
    output logic [SEL_BITS:0]   mux_addr
);
    localparam int WORD_LEN = 2 + SEL_BITS;
    localparam int CNT_W    = $clog2(WORD_LEN + 1);

    fe_state_t              st;
    logic [CNT_W-1:0]       cnt;
    logic [WORD_LEN-2:0]    shreg;
    logic [WORD_LEN-1:0]    word_now;
    logic                   last_bit;

    // Word as it stands once the current din bit is included.
    assign word_now = {shreg, din};
    // The current rising edge takes the final word bit.
    assign last_bit = (st == FE_ADDR) && (cnt == CNT_W'(WORD_LEN - 1));
    // Start pulse for the SAR core, valid only under an active select.
    assign conv_start = last_bit && rst_n && !cs_n;

    // Phase tracking, start-bit detection and word shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            st    <= FE_HUNT;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            case (st)
                FE_HUNT: begin
                    if (din) begin
                        st  <= FE_ADDR;
                        cnt <= '0;
                    end
                end
                FE_ADDR: begin
                    shreg <= word_now[WORD_LEN-2:0];
                    cnt   <= cnt + CNT_W'(1);
                    if (last_bit) begin
                        st <= FE_LOCK;
                    end
                end
                default: begin
                    st <= FE_LOCK;
                end
            endcase
        end
    end

    // Load the multiplexer controls when the word completes.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            mux_single <= 1'b0;
            mux_addr   <= '0;
        end else if (last_bit) begin
            mux_single <= word_now[WORD_LEN-1];
            mux_addr   <= word_now[WORD_LEN-2:0];
        end
    end

    // R2: a zero while hunting never leaves the hunt phase.
    p_zero_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FE_HUNT && !cs_n && !din) |=> (st == FE_HUNT));

    // R5: once locked, din cannot restart or retarget the multiplexer.
    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FE_LOCK && !cs_n) |=>
            (st == FE_LOCK) && $stable(mux_addr) && $stable(mux_single));

endmodule

// File: rtl/sar_seq_core.sv
// Module: successive-approximation register. On conv_start it loads the
// mid-scale trial. On each following rising edge it resolves one bit from
// the comparator, MSB first, and reports the verdict for the output stage.
// Assumes: cmp_hi is settled for the current dac_code before each edge.
module sar_seq_core #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                conv_start,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] dac_code,
    output logic                running,
    output logic                finished,
    output logic                dec_bit,
    output logic                dec_valid
);
    localparam int STEP_W = $clog2(RES_BITS + 1);
    localparam logic [RES_BITS-1:0] MID = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [STEP_W-1:0]   step;
    logic [RES_BITS-1:0] sar_next;
    int                  trial_idx;

    // Bit position under test at this edge.
    assign trial_idx = RES_BITS - 1 - int'(step);

    // Next trial code: resolve the tested bit and arm the one below it.
    always_comb begin
        sar_next = dac_code;
        for (int i = 0; i < RES_BITS; i++) begin
            if (i == trial_idx && !cmp_hi) begin
                sar_next[i] = 1'b0;
            end
            if (i + 1 == trial_idx) begin
                sar_next[i] = 1'b1;
            end
        end
    end

    // Step sequencing, SAR register and verdict capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code  <= '0;
            step      <= '0;
            running   <= 1'b0;
            finished  <= 1'b0;
            dec_bit   <= 1'b0;
            dec_valid <= 1'b0;
        end else if (cs_n) begin
            step      <= '0;
            running   <= 1'b0;
            finished  <= 1'b0;
            dec_bit   <= 1'b0;
            dec_valid <= 1'b0;
        end else if (conv_start) begin
            dac_code  <= MID;
            step      <= '0;
            running   <= 1'b1;
            finished  <= 1'b0;
            dec_bit   <= 1'b0;
            dec_valid <= 1'b0;
        end else if (running) begin
            dac_code  <= sar_next;
            dec_bit   <= cmp_hi;
            dec_valid <= 1'b1;
            step      <= step + STEP_W'(1);
            if (step == STEP_W'(RES_BITS - 1)) begin
                running  <= 1'b0;
                finished <= 1'b1;
            end
        end
    end

    // R6: every conversion starts from the mid-scale trial.
    p_mid_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (dac_code == MID));

    // R6: a high verdict never clears any bit already set.
    p_keep_on_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cs_n && !conv_start && cmp_hi) |=>
            (($past(dac_code) & dac_code) == $past(dac_code)));

    // R8: the final result holds while select stays low.
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (finished && !cs_n && !conv_start) |=> $stable(dac_code));

endmodule

// File: rtl/sar_seq_outstage.sv
// Module: falling-edge output stage. Turns the core's rising-edge state
// into busy, output enable and the serial data bit, half a clock later.
// Assumes: core state already clears on chip select high.
module sar_seq_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic running,
    input  logic finished,
    input  logic dec_bit,
    input  logic dec_valid,
    output logic dout,
    output logic dout_oe,
    output logic busy
);
    // Present status and verdict on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
            busy    <= 1'b0;
        end else begin
            busy    <= running;
            dout_oe <= running || finished;
            dout    <= dec_valid && dec_bit;
        end
    end

    // R4: busy never shows without the output driver enabled.
    p_busy_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dout_oe);

    // R1: select high at a rising edge floats the output by the next one.
    p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && !busy));

endmodule

// File: rtl/sar_serial_seq.sv
// Module: top of the serial SAR conversion sequencer. Joins the serial
// front end, the SAR core and the falling-edge output stage.
// Assumes: one clock (the serial clock); the pad buffer uses dout_oe.
module sar_serial_seq #(
    parameter int SEL_BITS = 2,
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                din,
    input  logic                cmp_hi,
    output logic                dout,
    output logic                dout_oe,
    output logic                busy,
    output logic                mux_single,
    output logic [SEL_BITS:0]   mux_addr,
    output logic [RES_BITS-1:0] dac_code
);
    logic conv_start;
    logic running;
    logic finished;
    logic dec_bit;
    logic dec_valid;

    sar_seq_frontend #(.SEL_BITS(SEL_BITS)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .din        (din),
        .conv_start (conv_start),
        .mux_single (mux_single),
        .mux_addr   (mux_addr)
    );

    sar_seq_core #(.RES_BITS(RES_BITS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .conv_start (conv_start),
        .cmp_hi     (cmp_hi),
        .dac_code   (dac_code),
        .running    (running),
        .finished   (finished),
        .dec_bit    (dec_bit),
        .dec_valid  (dec_valid)
    );

    sar_seq_outstage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .running   (running),
        .finished  (finished),
        .dec_bit   (dec_bit),
        .dec_valid (dec_valid),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .busy      (busy)
    );

endmodule

// File: tb/sar_serial_seq_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard check of the serial SAR sequencer with a behavioural
// comparator (cmp_hi = test value >= dac_code).
module sar_serial_seq_bench;
    localparam int SEL_BITS = 2;
    localparam int RES_BITS = 8;
    localparam int WORD_LEN = 2 + SEL_BITS;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cs_n = 1'b1;
    logic                din = 1'b0;
    logic                cmp_hi;
    logic                dout, dout_oe, busy, mux_single;
    logic [SEL_BITS:0]   mux_addr;
    logic [RES_BITS-1:0] dac_code;
    logic [RES_BITS-1:0] vin = '0;

    int tests = 0;
    int fails = 0;

    typedef struct { logic val; int idx; } sb_item_t;
    sb_item_t exp_q[$];
    logic     sb_en = 1'b0;
    logic     prev_busy = 1'b0;

    always #4 clk = ~clk;

    assign cmp_hi = (vin >= dac_code);

    sar_serial_seq #(.SEL_BITS(SEL_BITS), .RES_BITS(RES_BITS)) u_sar_serial_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .cmp_hi(cmp_hi),
        .dout(dout), .dout_oe(dout_oe), .busy(busy), .mux_single(mux_single),
        .mux_addr(mux_addr), .dac_code(dac_code)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance to one ns after the next falling edge (input drive point).
    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    // Expected trial code after k decisions (R6).
    function automatic logic [7:0] trial_exp(input logic [7:0] v, input int k);
        int m;
        int t;
        m = (255 << (8 - k)) & 255;
        t = (k < 8) ? (1 << (7 - k)) : 0;
        return (v & 8'(m)) | 8'(t);
    endfunction

    // Monitor: pops one expected serial bit per busy sample (R4, R7, R8).
    always @(negedge clk) begin
        #3;
        if (sb_en) begin
            if (busy || (prev_busy && dout_oe)) begin
                if (exp_q.size() == 0) begin
                    chk("R7", "unexpected serial bit", 32'(dout), 32'hx);
                end else begin
                    chk(exp_q[0].idx == 0 ? "R4" : "R7", "serial bit",
                        32'(dout), 32'(exp_q[0].val));
                    void'(exp_q.pop_front());
                end
            end
            prev_busy = busy;
        end else begin
            prev_busy = 1'b0;
        end
    end

    // Driver: one full conversion with scoreboard expectations.
    task automatic do_conv(input int nz, input logic single,
                           input logic [SEL_BITS:0] addr,
                           input logic [7:0] val, input logic junk);
        logic [WORD_LEN-1:0] word;
        sb_item_t it;
        word = {single, addr};
        vin  = val;
        exp_q.delete();
        it.val = 1'b0; it.idx = 0;
        exp_q.push_back(it);
        for (int b = 0; b < 8; b++) begin
            it.val = val[7 - b]; it.idx = b + 1;
            exp_q.push_back(it);
        end
        sb_en = 1'b1;
        cyc(); cs_n = 1'b0; din = 1'b0; #2;
        chk("R2", "oe while hunting", 32'(dout_oe), 0);
        for (int z = 0; z < nz; z++) begin
            cyc(); din = 1'b0; #2;
            chk("R2", "busy on leading zero", 32'(busy), 0);
        end
        cyc(); din = 1'b1; #2;
        for (int i = 0; i < WORD_LEN; i++) begin
            cyc(); din = word[WORD_LEN - 1 - i]; #2;
            chk("R2", "oe during word", 32'(dout_oe), 0);
        end
        for (int k = 0; k <= 8; k++) begin
            cyc(); din = junk ? 1'($urandom) : 1'b0; #2;
            if (k == 0) begin
                chk("R4", "busy rise", 32'(busy), 1);
                chk("R4", "oe on", 32'(dout_oe), 1);
                chk("R3", "mux_single", 32'(mux_single), 32'(single));
                chk("R3", "mux_addr", 32'(mux_addr), 32'(addr));
            end
            if (k < 8) begin
                chk("R8", "busy during conversion", 32'(busy), 1);
            end else begin
                chk("R8", "busy fall", 32'(busy), 0);
                chk("R8", "oe holds", 32'(dout_oe), 1);
            end
            chk("R6", "trial code", 32'(dac_code), 32'(trial_exp(val, k)));
        end
        cyc(); #2;
        chk("R7", "all bits delivered", 32'(exp_q.size()), 0);
        sb_en = 1'b0;
        // R5: a fresh start pattern after the word must not restart.
        cyc(); din = 1'b1; #2;
        for (int i = 0; i < WORD_LEN + 2; i++) begin
            cyc(); din = ~single; #2;
            chk("R5", "no restart", 32'(busy), 0);
        end
        chk("R5", "mux_addr held", 32'(mux_addr), 32'(addr));
        chk("R5", "result held", 32'(dac_code), 32'(val));
        cyc(); cs_n = 1'b1; din = 1'b0;
        cyc(); #2;
        chk("R1", "oe released", 32'(dout_oe), 0);
        chk("R1", "busy released", 32'(busy), 0);
    endtask

    // Driver: start a conversion and cut it off after a few decisions.
    task automatic do_abort(input logic use_reset);
        sb_en = 1'b0;
        vin = 8'h5A;
        cyc(); cs_n = 1'b0; din = 1'b1; #2;
        for (int i = 0; i < WORD_LEN; i++) begin
            cyc(); din = 1'b0; #2;
        end
        for (int k = 0; k < 3; k++) begin
            cyc(); #2;
        end
        chk("R9", "busy before cut", 32'(busy), 1);
        cyc();
        if (use_reset) rst_n = 1'b0; else cs_n = 1'b1;
        #2;
        cyc(); #2;
        chk(use_reset ? "R10" : "R9", "busy after cut", 32'(busy), 0);
        chk(use_reset ? "R10" : "R9", "oe after cut", 32'(dout_oe), 0);
        if (use_reset) chk("R10", "dac cleared", 32'(dac_code), 0);
        cyc(); rst_n = 1'b1; cs_n = 1'b1; #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: reset holds everything idle even with select low and din high.
        cs_n = 1'b0; din = 1'b1;
        repeat (3) begin cyc(); #2; end
        chk("R10", "oe in reset", 32'(dout_oe), 0);
        chk("R10", "busy in reset", 32'(busy), 0);
        chk("R10", "dac in reset", 32'(dac_code), 0);
        cyc(); rst_n = 1'b1; cs_n = 1'b1; din = 1'b0; #2;
        cyc(); #2;
        chk("R1", "idle oe", 32'(dout_oe), 0);

        do_conv(0, 1'b1, 3'd5, 8'hA5, 1'b0);
        do_conv(3, 1'b0, 3'd2, 8'h00, 1'b1);
        do_conv(1, 1'b1, 3'd7, 8'hFF, 1'b1);
        do_conv(5, 1'b0, 3'd0, 8'h3C, 1'b1);
        do_abort(1'b0);
        // R9: a new start bit is needed and then works normally.
        do_conv(2, 1'b1, 3'd1, 8'h81, 1'b0);
        do_abort(1'b1);
        for (int r = 0; r < 4; r++) begin
            do_conv(r, 1'($urandom), 3'($urandom), 8'($urandom), 1'b1);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule